// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside an instruction sequencer and makes the interrupt decision at the first state of every instruction fetch. Each time the core signals that a new instruction cycle is starting, the block looks at the pending requests. A request can come from an external device, which supplies a request bit, a three-bit priority and an eight-bit vector. It can also come from the keyboard status word, which carries a fixed priority and vector. The block compares the winning priority with the priority field held in the running status word. If the request does not win, the core is told at once to go on fetching.

When an interrupt is accepted, the block takes over a single-port memory interface and runs a fixed entry sequence. It writes the old status word and then the old program counter onto a stack that grows downward. Next it reads the handler address from a vector table. In its last step it gives the core a new program counter, a new stack pointer and a new status word. The new status word carries the accepted priority and has the privilege bit cleared. The cycle after that, the core starts an ordinary fetch at the handler.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, no memory access, no register load, no busy indication and no fetch-continue pulse are issued until a fetch start is seen.
- R2: An interrupt is taken only when the winning priority is strictly greater than status word bits [10:8]. If the winning priority is equal or lower, fetch_go_o is high in the same cycle as fetch_start_i and no memory access follows.
- R3: Requests are evaluated only while fetch_start_i is high and the block is idle. A request at any other time causes no memory access and no fetch_go_o.
- R4: The keyboard requests only when kbd_status_i bit 15 (ready) and bit 14 (enable) are both 1. Its request uses priority KBD_PRI and vector KBD_VEC. Either bit alone raises no request.
- R5: When both sources qualify, the higher priority wins. On equal priority the external device wins.
- R6: The first access of the entry sequence writes the old status word to address SP-1, with the 16-bit address wrapping modulo 2^16.
- R7: The second access writes the old program counter to address SP-2, with the same wrapping.
- R8: The third access is a read from address {8'h01, vector}, the vector table entry of the accepted source.
- R9: In the final step pc_load_o, sp_load_o and psr_load_o pulse for one cycle. At that step pc_o equals the read data, sp_o equals SP-2, and psr_o is the old status word with bits [10:8] set to the accepted priority, bit 15 cleared and all other bits kept.
- R10: While mem_req_o is high and mem_ready_i is low, the block holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stable and does not advance.
- R11: The cycle after the final step the block is idle again, and a new fetch start is evaluated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_start_i | input | 1 | Core is in the first fetch state |
| dev_req_i | input | 1 | External device service request |
| dev_pri_i | input | 3 | External device priority |
| dev_vec_i | input | 8 | External device vector |
| kbd_status_i | input | 16 | Keyboard status word (bit 15 ready, bit 14 enable) |
| psr_i | input | 16 | Current status word |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| fetch_go_o | output | 1 | No interrupt taken; continue fetch |
| irq_busy_o | output | 1 | Entry sequence in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_ready_i | input | 1 | Access completes this cycle |
| pc_load_o | output | 1 | Load program counter |
| pc_o | output | 16 | New program counter |
| sp_load_o | output | 1 | Load stack pointer |
| sp_o | output | 16 | New stack pointer |
| psr_load_o | output | 1 | Load status word |
| psr_o | output | 16 | New status word |

## Verification
The bench builds the block with a 16-bit word, priority field at bits [10:8], vector table base 8'h01, keyboard priority 4 and keyboard vector 8'h80. Setting the keyboard priority to 4 makes an equal-priority tie against the external device reachable, and it also lets a device win either above or below the keyboard. The 16-bit stack pointer lets a start value of 1 push across the wrap to 0xFFFF. The bench also adds memory wait states so that the hold behaviour of each access is observed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_SR = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_VEC_RD  = 3'd3,
    ST_LOAD    = 3'd4
  } seq_st_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int PRI_W = 3,
  parameter int VEC_W = 8,
  parameter bit KBD_EN = 1'b1,
  parameter logic [PRI_W-1:0] KBD_PRI = 3'd4,
  parameter logic [VEC_W-1:0] KBD_VEC = 8'h80
) (
  input  logic             dev_req_i,
  input  logic [PRI_W-1:0] dev_pri_i,
  input  logic [VEC_W-1:0] dev_vec_i,
  input  logic             kbd_rdy_i,
  input  logic             kbd_ie_i,
  input  logic [PRI_W-1:0] cur_pri_i,
  output logic             take_o,
  output logic [PRI_W-1:0] win_pri_o,
  output logic [VEC_W-1:0] win_vec_o
);
  logic kbd_req;
  logic dev_q, kbd_q, pick_dev;

  generate
    if (KBD_EN) begin : g_kbd
      assign kbd_req = kbd_rdy_i & kbd_ie_i;
    end else begin : g_nokbd
      logic unused_kbd;
      assign unused_kbd = kbd_rdy_i ^ kbd_ie_i;
      assign kbd_req = 1'b0;
    end
  endgenerate

  // strict greater-than against running priority
  assign dev_q = dev_req_i && (dev_pri_i > cur_pri_i);
  assign kbd_q = kbd_req && (KBD_PRI > cur_pri_i);
  // tie goes to the external device
  assign pick_dev = dev_q && (!kbd_q || (dev_pri_i >= KBD_PRI));

  assign take_o    = dev_q | kbd_q;
  assign win_pri_o = pick_dev ? dev_pri_i : KBD_PRI;
  assign win_vec_o = pick_dev ? dev_vec_i : KBD_VEC;
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fetch_start_i,
  input  logic    take_i,
  input  logic    mem_ready_i,
  output seq_st_e st_o,
  output logic    accept_o,
  output logic    step_o
);
  seq_st_e st_q, st_d;
  logic mem_phase;

  assign mem_phase = (st_q == ST_PUSH_SR) || (st_q == ST_PUSH_PC) || (st_q == ST_VEC_RD);
  assign step_o    = mem_phase && mem_ready_i;
  assign accept_o  = (st_q == ST_IDLE) && fetch_start_i && take_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept_o) st_d = ST_PUSH_SR;
      ST_PUSH_SR: if (step_o)   st_d = ST_PUSH_PC;
      ST_PUSH_PC: if (step_o)   st_d = ST_VEC_RD;
      ST_VEC_RD:  if (step_o)   st_d = ST_LOAD;
      ST_LOAD:                  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  AST_SEQ_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PUSH_PC) |-> ($past(st_q) == ST_PUSH_SR || $past(st_q) == ST_PUSH_PC)) // R7
    else $error("push order broken");
endmodule

// File: rtl/irq_ctx.sv
module irq_ctx
  import irq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PRI_W  = 3,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           st_i,
  input  logic              accept_i,
  input  logic              step_i,
  input  logic [PRI_W-1:0]  pri_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] psr_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [PRI_W-1:0]  pri_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] psr_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] hdl_o
);
  logic [PRI_W-1:0]  pri_q;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] pc_q, psr_q, sp_q, hdl_q;
  logic push_step;

  assign push_step = step_i && ((st_i == ST_PUSH_SR) || (st_i == ST_PUSH_PC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '0;
      vec_q <= '0;
      pc_q  <= '0;
      psr_q <= '0;
      sp_q  <= '0;
      hdl_q <= '0;
    end else begin
      if (accept_i) begin
        pri_q <= pri_i;
        vec_q <= vec_i;
        pc_q  <= pc_i;
        psr_q <= psr_i;
        sp_q  <= sp_i;
      end else if (push_step) begin
        sp_q <= sp_q - 1'b1;
      end
      if (step_i && st_i == ST_VEC_RD) hdl_q <= rdata_i;
    end
  end

  assign pri_o = pri_q;
  assign vec_o = vec_q;
  assign pc_o  = pc_q;
  assign psr_o = psr_q;
  assign sp_o  = sp_q;
  assign hdl_o = hdl_q;
endmodule

// File: rtl/irq_mem_mux.sv
module irq_mem_mux
  import irq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter logic [WORD_W-VEC_W-1:0] VEC_BASE = 8'h01
) (
  input  seq_st_e           st_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] psr_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              req_o,
  output logic              we_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [WORD_W-1:0] sp_dec;
  assign sp_dec = sp_i - 1'b1;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (st_i)
      ST_PUSH_SR: begin req_o = 1'b1; we_o = 1'b1; addr_o = sp_dec; wdata_o = psr_i; end
      ST_PUSH_PC: begin req_o = 1'b1; we_o = 1'b1; addr_o = sp_dec; wdata_o = pc_i;  end
      ST_VEC_RD:  begin req_o = 1'b1; addr_o = {VEC_BASE, vec_i}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PRI_W    = 3,
  parameter int VEC_W    = 8,
  parameter int PRI_LSB  = 8,
  parameter int PRIV_BIT = 15,
  parameter int KBD_RDY_BIT = 15,
  parameter int KBD_IE_BIT  = 14,
  parameter bit KBD_EN   = 1'b1,
  parameter logic [PRI_W-1:0] KBD_PRI = 3'd4,
  parameter logic [VEC_W-1:0] KBD_VEC = 8'h80,
  parameter logic [WORD_W-VEC_W-1:0] VEC_BASE = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_start_i,
  input  logic              dev_req_i,
  input  logic [PRI_W-1:0]  dev_pri_i,
  input  logic [VEC_W-1:0]  dev_vec_i,
  input  logic [WORD_W-1:0] kbd_status_i,
  input  logic [WORD_W-1:0] psr_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              fetch_go_o,
  output logic              irq_busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              pc_load_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              sp_load_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              psr_load_o,
  output logic [WORD_W-1:0] psr_o
);
  seq_st_e st;
  logic take, accept, step;
  logic [PRI_W-1:0]  win_pri, ctx_pri;
  logic [VEC_W-1:0]  win_vec, ctx_vec;
  logic [WORD_W-1:0] ctx_pc, ctx_psr, ctx_sp, ctx_hdl;
  logic [WORD_W-1:0] new_psr;
  logic              unused_kbd_bits;

  assign unused_kbd_bits = ^kbd_status_i;

  irq_qualify #(
    .PRI_W(PRI_W), .VEC_W(VEC_W), .KBD_EN(KBD_EN),
    .KBD_PRI(KBD_PRI), .KBD_VEC(KBD_VEC)
  ) u_qual (
    .dev_req_i (dev_req_i),
    .dev_pri_i (dev_pri_i),
    .dev_vec_i (dev_vec_i),
    .kbd_rdy_i (kbd_status_i[KBD_RDY_BIT]),
    .kbd_ie_i  (kbd_status_i[KBD_IE_BIT]),
    .cur_pri_i (psr_i[PRI_LSB +: PRI_W]),
    .take_o    (take),
    .win_pri_o (win_pri),
    .win_vec_o (win_vec)
  );

  irq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_start_i (fetch_start_i),
    .take_i        (take),
    .mem_ready_i   (mem_ready_i),
    .st_o          (st),
    .accept_o      (accept),
    .step_o        (step)
  );

  irq_ctx #(.WORD_W(WORD_W), .PRI_W(PRI_W), .VEC_W(VEC_W)) u_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st),
    .accept_i (accept),
    .step_i   (step),
    .pri_i    (win_pri),
    .vec_i    (win_vec),
    .pc_i     (pc_i),
    .psr_i    (psr_i),
    .sp_i     (sp_i),
    .rdata_i  (mem_rdata_i),
    .pri_o    (ctx_pri),
    .vec_o    (ctx_vec),
    .pc_o     (ctx_pc),
    .psr_o    (ctx_psr),
    .sp_o     (ctx_sp),
    .hdl_o    (ctx_hdl)
  );

  irq_mem_mux #(.WORD_W(WORD_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_mux (
    .st_i    (st),
    .sp_i    (ctx_sp),
    .pc_i    (ctx_pc),
    .psr_i   (ctx_psr),
    .vec_i   (ctx_vec),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  // priority field replaced, supervisor mode forced
  always_comb begin
    new_psr = ctx_psr;
    new_psr[PRI_LSB +: PRI_W] = ctx_pri;
    new_psr[PRIV_BIT] = 1'b0;
  end

  assign fetch_go_o = (st == ST_IDLE) && fetch_start_i && !take;
  assign irq_busy_o = (st != ST_IDLE);
  assign pc_load_o  = (st == ST_LOAD);
  assign sp_load_o  = (st == ST_LOAD);
  assign psr_load_o = (st == ST_LOAD);
  assign pc_o  = ctx_hdl;
  assign sp_o  = ctx_sp;
  assign psr_o = new_psr;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o))) // R10
    else $error("access not held");
  AST_PRIV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_load_o |-> !psr_o[PRIV_BIT]) // R9
    else $error("privilege not cleared");
  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !irq_busy_o) // R11
    else $error("not idle after load");
  AST_GO_NOBUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_go_o |=> !irq_busy_o && !mem_req_o) // R2
    else $error("access after fetch continue");
  AST_FIRST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_busy_o) |-> (mem_req_o && mem_we_o && mem_wdata_o == $past(psr_i))) // R6
    else $error("first access not status push");
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_busy_o |-> !mem_req_o && !pc_load_o) // R1
    else $error("activity while idle");
endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } mem_op_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_start_i = 1'b0;
  logic        dev_req_i = 1'b0;
  logic [2:0]  dev_pri_i = '0;
  logic [7:0]  dev_vec_i = '0;
  logic [15:0] kbd_status_i = '0;
  logic [15:0] psr_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] sp_i = '0;
  logic        fetch_go_o, irq_busy_o, mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;
  logic        pc_load_o, sp_load_o, psr_load_o;
  logic [15:0] pc_o, sp_o, psr_o;

  int checks = 0;
  int failures = 0;
  int mem_wait = 0;
  int wcnt = 0;
  mem_op_t exp_q[$];
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr = '0, prev_wdata = '0;

  always #5 clk = ~clk;

  irq_entry_seq #(
    .WORD_W(16), .PRI_W(3), .VEC_W(8), .PRI_LSB(8), .PRIV_BIT(15),
    .KBD_RDY_BIT(15), .KBD_IE_BIT(14), .KBD_EN(1'b1),
    .KBD_PRI(3'd4), .KBD_VEC(8'h80), .VEC_BASE(8'h01)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_start_i(fetch_start_i),
    .dev_req_i(dev_req_i), .dev_pri_i(dev_pri_i), .dev_vec_i(dev_vec_i),
    .kbd_status_i(kbd_status_i), .psr_i(psr_i), .pc_i(pc_i), .sp_i(sp_i),
    .fetch_go_o(fetch_go_o), .irq_busy_o(irq_busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .pc_load_o(pc_load_o), .pc_o(pc_o), .sp_load_o(sp_load_o), .sp_o(sp_o),
    .psr_load_o(psr_load_o), .psr_o(psr_o)
  );

  // vector table model: handler address derived from table address
  assign mem_rdata_i = {4'h3, mem_addr_o[7:0], 4'h0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: ready after mem_wait stall cycles
  always @(posedge clk) begin
    #2;
    if (mem_ready_i) begin
      mem_ready_i = 1'b0;
      wcnt = mem_wait;
    end else if (mem_req_o) begin
      if (wcnt == 0) mem_ready_i = 1'b1;
      else wcnt--;
    end else begin
      wcnt = mem_wait;
    end
  end

  // monitor: pop expected accesses as they complete
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_stall) begin
        chk(mem_req_o && mem_addr_o == prev_addr && mem_wdata_o == prev_wdata,
            "R10 hold", {15'd0, mem_req_o, mem_addr_o}, {16'd1, prev_addr});
      end
      prev_stall = mem_req_o && !mem_ready_i;
      prev_addr  = mem_addr_o;
      prev_wdata = mem_wdata_o;
      if (mem_req_o && mem_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R3 unexpected access", {16'd0, mem_addr_o}, 32'd0);
        end else begin
          mem_op_t e;
          e = exp_q.pop_front();
          chk(mem_we_o == e.we && mem_addr_o == e.addr,
              e.we ? "R6/R7 push addr" : "R8 vector addr",
              {15'd0, mem_we_o, mem_addr_o}, {15'd0, e.we, e.addr});
          if (e.we) chk(mem_wdata_o == e.data, "R6/R7 push data", {16'd0, mem_wdata_o}, {16'd0, e.data});
        end
      end
    end
  end

  task automatic do_fetch(input logic dreq, input logic [2:0] dpri, input logic [7:0] dvec,
                          input logic [15:0] kbd, input logic [15:0] psr, input logic [15:0] pc,
                          input logic [15:0] sp, input bit exp_take, input logic [2:0] epri,
                          input logic [7:0] evec, input string tag);
    logic [15:0] epsr;
    int guard;
    @(negedge clk);
    dev_req_i = dreq; dev_pri_i = dpri; dev_vec_i = dvec;
    kbd_status_i = kbd; psr_i = psr; pc_i = pc; sp_i = sp;
    fetch_start_i = 1'b1;
    #1;
    chk(fetch_go_o == !exp_take, tag, {31'd0, fetch_go_o}, {31'd0, !exp_take});
    if (exp_take) begin
      exp_q.push_back('{we: 1'b1, addr: sp - 16'd1, data: psr});
      exp_q.push_back('{we: 1'b1, addr: sp - 16'd2, data: pc});
      exp_q.push_back('{we: 1'b0, addr: {8'h01, evec}, data: 16'h0});
    end
    @(negedge clk);
    fetch_start_i = 1'b0;
    dev_req_i = 1'b0;
    kbd_status_i = '0;
    if (!exp_take) begin
      chk(!mem_req_o && !irq_busy_o, "R2 no entry", {30'd0, mem_req_o, irq_busy_o}, 32'd0);
      return;
    end
    guard = 0;
    while (!pc_load_o && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    epsr = psr;
    epsr[10:8] = epri;
    epsr[15] = 1'b0;
    chk(pc_load_o && sp_load_o && psr_load_o, "R9 load pulse", {29'd0, pc_load_o, sp_load_o, psr_load_o}, 32'd7);
    chk(pc_o == {4'h3, evec, 4'h0}, "R9 handler pc", {16'd0, pc_o}, {16'd0, 4'h3, evec, 4'h0});
    chk(sp_o == sp - 16'd2, "R9 new sp", {16'd0, sp_o}, {16'd0, sp - 16'd2});
    chk(psr_o == epsr, "R9 new psr", {16'd0, psr_o}, {16'd0, epsr});
    chk(exp_q.size() == 0, "R8 all accesses done", exp_q.size(), 32'd0);
    @(negedge clk);
    chk(!irq_busy_o && !pc_load_o, "R11 idle after load", {30'd0, irq_busy_o, pc_load_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req_o && !irq_busy_o && !pc_load_o && !fetch_go_o, "R1 reset state",
        {28'd0, mem_req_o, irq_busy_o, pc_load_o, fetch_go_o}, 32'd0);

    // R3 request without fetch start is ignored
    dev_req_i = 1'b1; dev_pri_i = 3'd7; dev_vec_i = 8'h22; psr_i = 16'h8000;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req_o && !fetch_go_o && !irq_busy_o, "R3 ignored",
          {29'd0, mem_req_o, fetch_go_o, irq_busy_o}, 32'd0);
    end
    dev_req_i = 1'b0;

    // R2 equal and lower priority
    do_fetch(1'b1, 3'd3, 8'h10, 16'h0, 16'h0300, 16'h3000, 16'h3000, 1'b0, 3'd0, 8'h0, "R2 equal no take");
    do_fetch(1'b1, 3'd2, 8'h10, 16'h0, 16'h0500, 16'h3000, 16'h3000, 1'b0, 3'd0, 8'h0, "R2 lower no take");
    do_fetch(1'b0, 3'd7, 8'h10, 16'h0, 16'h8000, 16'h3000, 16'h3000, 1'b0, 3'd0, 8'h0, "R2 no request go");

    // R2 R6 R7 R8 R9 take from user level
    do_fetch(1'b1, 3'd1, 8'h81, 16'h0, 16'h8002, 16'h3005, 16'h2FF0, 1'b1, 3'd1, 8'h81, "R2 take");

    // R10 with wait states, other status bits kept
    mem_wait = 2;
    do_fetch(1'b1, 3'd7, 8'hF3, 16'h0, 16'hF6A5, 16'h1234, 16'h4000, 1'b1, 3'd7, 8'hF3, "R10 take waits");
    mem_wait = 0;

    // R6 R7 stack wrap
    do_fetch(1'b1, 3'd5, 8'h01, 16'h0, 16'h0000, 16'hABCD, 16'h0001, 1'b1, 3'd5, 8'h01, "R7 wrap take");

    // R4 keyboard
    do_fetch(1'b0, 3'd0, 8'h00, 16'hC000, 16'h8000, 16'h3100, 16'h3000, 1'b1, 3'd4, 8'h80, "R4 kbd take");
    do_fetch(1'b0, 3'd0, 8'h00, 16'h8000, 16'h8000, 16'h3100, 16'h3000, 1'b0, 3'd0, 8'h0, "R4 ready only");
    do_fetch(1'b0, 3'd0, 8'h00, 16'h4000, 16'h8000, 16'h3100, 16'h3000, 1'b0, 3'd0, 8'h0, "R4 enable only");
    do_fetch(1'b0, 3'd0, 8'h00, 16'hC000, 16'h0400, 16'h3100, 16'h3000, 1'b0, 3'd0, 8'h0, "R4 kbd equal");

    // R5 arbitration
    do_fetch(1'b1, 3'd6, 8'h41, 16'hC000, 16'h0000, 16'h2000, 16'h3000, 1'b1, 3'd6, 8'h41, "R5 device higher");
    do_fetch(1'b1, 3'd2, 8'h42, 16'hC000, 16'h0100, 16'h2000, 16'h3000, 1'b1, 3'd4, 8'h80, "R5 kbd higher");
    do_fetch(1'b1, 3'd4, 8'h43, 16'hC000, 16'h0000, 16'h2000, 16'h3000, 1'b1, 3'd4, 8'h43, "R5 tie device");

    // R11 back to back evaluation
    do_fetch(1'b1, 3'd3, 8'h55, 16'h0, 16'h0200, 16'h5000, 16'h6000, 1'b1, 3'd3, 8'h55, "R11 first");
    do_fetch(1'b1, 3'd3, 8'h55, 16'h0, 16'h0300, 16'h5000, 16'h6000, 1'b0, 3'd0, 8'h0, "R11 next eval");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule